// File: doc/BRIEF.md
# Overwrite-Oldest Multichannel Message FIFO

This block buffers 32-bit words received on eight serial avionics channels. Each channel has its own first-in first-out queue of up to 32 words. All eight queues share one storage array of 256 words (1024 bytes), and each channel owns a fixed 32-word slice of it. Words that an upstream filter has accepted arrive on a single push port tagged with their channel. A host-side command decoder empties a queue through a channel-indexed pop strobe, and the popped word appears one cycle later.

When a queue already holds 32 words and another word arrives, the new word is still stored and the oldest one is dropped. The host therefore always finds the most recent 32 words of a channel. Three 8-bit status vectors report not-empty, above-threshold and full, one bit per channel. A 2-bit select per channel picks which of these conditions raises that channel's interrupt. The channel interrupts are ORed into one pending flag.

Top module: `msg_fifo_bank`

## Requirements
- R1: After reset, all three status vectors are zero, `irq_flag` is 0 and `pop_data` is 0.
- R2: A push to channel c sets `stat_nempty[c]` on the cycle after the push edge. The bit stays set while the channel holds at least one word.
- R3: Each channel returns its words in the order they were pushed, independently of the other channels. The word from a pop strobe appears on `pop_data` on the cycle after the strobe edge and holds until the next strobe.
- R4: `stat_thresh[c]` is 1 exactly when channel c holds more words than the value on `thresh`. A `thresh` of 32 or more never sets it.
- R5: `stat_full[c]` is 1 exactly when channel c holds 32 words.
- R6: A push to a full channel with no pop on that channel stores the new word and discards the oldest. The count stays at 32, and the next pop returns the oldest surviving word.
- R7: A pop on an empty channel gives `pop_data` = 0 and changes no channel's contents or status.
- R8: A push and a pop on the same non-empty channel in one cycle leave its count unchanged. The pop returns the oldest word. On an empty channel the pop returns 0 and the pushed word is kept.
- R9: Bits [2c+1:2c] of `irq_sel` select the interrupt source of channel c. The encoding is 00 = none, 01 = not-empty, 10 = threshold, 11 = full. `irq_flag` is the OR of all channel interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Store `push_data` into channel `push_ch` |
| push_ch | input | 3 | Channel of the pushed word |
| push_data | input | 32 | Word to store |
| pop_valid | input | 1 | Remove the oldest word of channel `pop_ch` |
| pop_ch | input | 3 | Channel to pop |
| pop_data | output | 32 | Popped word, one cycle after the strobe |
| thresh | input | 6 | Threshold shared by all channels |
| irq_sel | input | 16 | Interrupt source select, 2 bits per channel |
| stat_nempty | output | 8 | Not-empty flag per channel |
| stat_thresh | output | 8 | Count above threshold, per channel |
| stat_full | output | 8 | Count equals 32, per channel |
| irq_flag | output | 1 | OR of the per-channel interrupts |

## Verification
The assertions check the following on every cycle:
- A push always leaves its channel not-empty.
- A full channel stays full when it is pushed without a pop.
- An empty-channel pop yields zero.
- Full and above-threshold each imply not-empty.
- The pending flag can rise only when some channel holds data, and never while every select is zero.
- An out-of-range threshold keeps every threshold bit clear.

Only the bench's scenarios show the rest. These are the word order per channel and which word the overwrite drops. They also include the exact threshold crossing points, each select encoding, and the isolation between channels, all compared with a queue model.

// File: rtl/msg_fifo_pkg.sv
// Package: shared constants and the interrupt-source encoding for the
// message FIFO bank. Assumes nothing beyond IEEE 1800-2017.
package msg_fifo_pkg;

    localparam int DEF_NUM_CH = 8;
    localparam int DEF_DEPTH  = 32;
    localparam int DEF_WORD_W = 32;

    // Per-channel interrupt source select, 2 bits per channel.
    typedef enum logic [1:0] {
        SRC_OFF    = 2'b00,
        SRC_NEMPTY = 2'b01,
        SRC_THRESH = 2'b10,
        SRC_FULL   = 2'b11
    } irq_src_e;

endpackage

// File: rtl/msg_fifo_ctrl.sv
// Module: pointer and count keeper for one channel queue.
// It tracks the write slot, the read slot and the occupancy. A push
// into a full queue advances the read slot too, so the oldest word is
// dropped. A pop into an empty queue is refused.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module msg_fifo_ctrl #(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] thresh,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             pop_ok,
    output logic             nempty,
    output logic             above,
    output logic             full
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;
    logic             drop;

    // Derive the flags from the current occupancy.
    always_comb begin
        nempty = (count != '0);
        above  = (count > thresh);
        full   = (count == FULL_CNT);
    end

    // A pop is honoured only with data present; a full push drops the oldest word.
    always_comb begin
        pop_ok = pop && nempty;
        drop   = push && full && !pop_ok;
    end

    // Advance the slots and update the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop_ok || drop) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            if (push && !pop_ok && !full) begin
                count <= count + CNT_W'(1);
            end else if (pop_ok && !push) begin
                count <= count - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/msg_fifo_store.sv
// Module: shared word array for all channel queues.
// It has one write port and one registered read port. The address is
// {channel, slot}, so each channel owns a fixed contiguous slice.
// A refused pop loads zero into the read register. The register holds
// its value when no pop strobe is present.
module msg_fifo_store #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic              rzero,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [WORDS];

    // Write the accepted word into its slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Capture the popped word, or zero for a refused pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end else if (rzero) begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/msg_fifo_irq.sv
// Module: interrupt source selection and gathering.
// For each channel it picks one status condition with the 2-bit select
// and ORs all channel requests into a single pending flag.
module msg_fifo_irq
    import msg_fifo_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0]   nempty,
    input  logic [NUM_CH-1:0]   above,
    input  logic [NUM_CH-1:0]   full,
    input  logic [2*NUM_CH-1:0] sel,
    output logic                flag
);

    logic [NUM_CH-1:0] ch_req;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        irq_src_e src;
        assign src = irq_src_e'(sel[2*c +: 2]);
        // Choose the condition this channel reports.
        always_comb begin
            unique case (src)
                SRC_NEMPTY: ch_req[c] = nempty[c];
                SRC_THRESH: ch_req[c] = above[c];
                SRC_FULL:   ch_req[c] = full[c];
                default:    ch_req[c] = 1'b0;
            endcase
        end
    end

    // Merge all channel requests into the pending flag.
    always_comb begin
        flag = |ch_req;
    end

endmodule

// File: rtl/msg_fifo_bank.sv
// Module: bank of per-channel overwrite-oldest message queues over one
// shared array.
// It routes the channel-tagged push and pop strobes to the per-channel
// controllers and forms the shared-array addresses. It also exposes the
// status vectors and the merged interrupt.
// Assumes NUM_CH and DEPTH are powers of two and at most one push and
// one pop arrive per cycle.
module msg_fifo_bank
    import msg_fifo_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int DEPTH  = DEF_DEPTH,
    parameter int WORD_W = DEF_WORD_W,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = CH_W + PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [CH_W-1:0]     push_ch,
    input  logic [WORD_W-1:0]   push_data,
    input  logic                pop_valid,
    input  logic [CH_W-1:0]     pop_ch,
    output logic [WORD_W-1:0]   pop_data,
    input  logic [CNT_W-1:0]    thresh,
    input  logic [2*NUM_CH-1:0] irq_sel,
    output logic [NUM_CH-1:0]   stat_nempty,
    output logic [NUM_CH-1:0]   stat_thresh,
    output logic [NUM_CH-1:0]   stat_full,
    output logic                irq_flag
);

    logic [PTR_W-1:0]  wr_ptr [NUM_CH];
    logic [PTR_W-1:0]  rd_ptr [NUM_CH];
    logic [NUM_CH-1:0] push_hit;
    logic [NUM_CH-1:0] pop_hit;
    logic [NUM_CH-1:0] pop_ok;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              rd_en;
    logic              rd_zero;

    // Decode the channel-tagged strobes into per-channel strobes.
    always_comb begin
        push_hit = '0;
        pop_hit  = '0;
        if (push_valid) push_hit[push_ch] = 1'b1;
        if (pop_valid)  pop_hit[pop_ch]   = 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        msg_fifo_ctrl #(
            .DEPTH (DEPTH)
        ) u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (push_hit[c]),
            .pop    (pop_hit[c]),
            .thresh (thresh),
            .wr_ptr (wr_ptr[c]),
            .rd_ptr (rd_ptr[c]),
            .pop_ok (pop_ok[c]),
            .nempty (stat_nempty[c]),
            .above  (stat_thresh[c]),
            .full   (stat_full[c])
        );
    end

    // Form the shared-array addresses and the read controls.
    always_comb begin
        waddr   = {push_ch, wr_ptr[push_ch]};
        raddr   = {pop_ch, rd_ptr[pop_ch]};
        rd_en   = |pop_ok;
        rd_zero = pop_valid && !rd_en;
    end

    msg_fifo_store #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_valid),
        .waddr (waddr),
        .wdata (push_data),
        .re    (rd_en),
        .rzero (rd_zero),
        .raddr (raddr),
        .rdata (pop_data)
    );

    msg_fifo_irq #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .nempty (stat_nempty),
        .above  (stat_thresh),
        .full   (stat_full),
        .sel    (irq_sel),
        .flag   (irq_flag)
    );

endmodule

// File: rtl/msg_fifo_bank_chk.sv
// Module: property checker for msg_fifo_bank, attached through bind.
// It observes the top-level ports only.
module msg_fifo_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int DEPTH  = 32,
    parameter int WORD_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                push_valid,
    input logic [CH_W-1:0]     push_ch,
    input logic                pop_valid,
    input logic [CH_W-1:0]     pop_ch,
    input logic [WORD_W-1:0]   pop_data,
    input logic [CNT_W-1:0]    thresh,
    input logic [2*NUM_CH-1:0] irq_sel,
    input logic [NUM_CH-1:0]   stat_nempty,
    input logic [NUM_CH-1:0]   stat_thresh,
    input logic [NUM_CH-1:0]   stat_full,
    input logic                irq_flag
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_PUSH_NEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> stat_nempty[$past(push_ch)]); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && stat_full[push_ch] && !(pop_valid && pop_ch == push_ch))
        |=> stat_full[$past(push_ch)]); // R6

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !stat_nempty[pop_ch]) |=> (pop_data == '0)); // R7

    AST_FULL_NEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_full & ~stat_nempty) == '0); // R5

    AST_THR_NEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_thresh & ~stat_nempty) == '0); // R4

    AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh >= FULL_CNT) |-> (stat_thresh == '0)); // R4

    AST_FLAG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> (stat_nempty != '0)); // R9

    AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == '0) |-> !irq_flag); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (stat_nempty == '0 && pop_data == '0)); // R1

endmodule

bind msg_fifo_bank msg_fifo_bank_chk #(
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .push_ch     (push_ch),
    .pop_valid   (pop_valid),
    .pop_ch      (pop_ch),
    .pop_data    (pop_data),
    .thresh      (thresh),
    .irq_sel     (irq_sel),
    .stat_nempty (stat_nempty),
    .stat_thresh (stat_thresh),
    .stat_full   (stat_full),
    .irq_flag    (irq_flag)
);

// File: tb/sim_msg_fifo_bank.sv
// Bench: queue-based reference model, compared on every falling edge.
module sim_msg_fifo_bank;

    localparam int NCH = 8;
    localparam int DEP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [2:0]  push_ch = '0;
    logic [31:0] push_data = '0;
    logic        pop_valid = 1'b0;
    logic [2:0]  pop_ch = '0;
    logic [31:0] pop_data;
    logic [5:0]  thresh = 6'd2;
    logic [15:0] irq_sel = '0;
    logic [7:0]  stat_nempty, stat_thresh, stat_full;
    logic        irq_flag;

    int total = 0;
    int bad = 0;
    bit ovr_phase = 1'b0;
    bit finished = 1'b0;

    logic [31:0] mq [NCH][$];
    logic [31:0] exp_pd = '0;
    string       pd_tag = "R1";

    always #4 clk = ~clk;

    msg_fifo_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_ch(push_ch), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ch(pop_ch), .pop_data(pop_data),
        .thresh(thresh), .irq_sel(irq_sel),
        .stat_nempty(stat_nempty), .stat_thresh(stat_thresh),
        .stat_full(stat_full), .irq_flag(irq_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: pop first, then push (drop the oldest when full).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) mq[c].delete();
            exp_pd = '0;
            pd_tag = "R1";
        end else begin
            if (pop_valid) begin
                if (mq[pop_ch].size() == 0) begin
                    exp_pd = '0;
                    pd_tag = "R7";
                end else begin
                    exp_pd = mq[pop_ch].pop_front();
                    if (push_valid && push_ch == pop_ch) pd_tag = "R8";
                    else if (ovr_phase) pd_tag = "R6";
                    else pd_tag = "R3";
                end
            end
            if (push_valid) begin
                if (mq[push_ch].size() == DEP) void'(mq[push_ch].pop_front());
                mq[push_ch].push_back(push_data);
            end
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] en, et, ef;
            logic       eirq;
            eirq = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                en[c] = mq[c].size() > 0;
                et[c] = mq[c].size() > int'(thresh);
                ef[c] = mq[c].size() == DEP;
                case (irq_sel[2*c +: 2])
                    2'b01: eirq |= en[c];
                    2'b10: eirq |= et[c];
                    2'b11: eirq |= ef[c];
                    default: ;
                endcase
            end
            check("R2 nempty", {24'd0, stat_nempty}, {24'd0, en});
            check("R4 thresh", {24'd0, stat_thresh}, {24'd0, et});
            check("R5 full", {24'd0, stat_full}, {24'd0, ef});
            check("R9 irq_flag", {31'd0, irq_flag}, {31'd0, eirq});
            check({pd_tag, " pop_data"}, pop_data, exp_pd);
        end
    end

    task automatic step(input bit pv, input int pc, input logic [31:0] pd,
                        input bit ov, input int oc);
        @(negedge clk);
        push_valid = pv; push_ch = 3'(pc); push_data = pd;
        pop_valid = ov; pop_ch = 3'(oc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 nempty", {24'd0, stat_nempty}, 32'd0);
        check("R1 thresh", {24'd0, stat_thresh}, 32'd0);
        check("R1 full", {24'd0, stat_full}, 32'd0);
        check("R1 irq", {31'd0, irq_flag}, 32'd0);
        check("R1 pop_data", pop_data, 32'd0);

        // R2/R3/R4: order and isolation across channels, threshold crossing
        for (int i = 0; i < 4; i++) step(1, 0, 32'hA000_0000 + i, 0, 0);
        step(1, 5, 32'h5555_0001, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 5);
        idle(2);

        // R9: each select encoding on channel 3
        step(1, 3, 32'h3333_0000, 0, 0);
        irq_sel = 16'h0040; idle(2);
        irq_sel = 16'h0080; idle(2);
        step(1, 3, 32'h3333_0001, 0, 0);
        step(1, 3, 32'h3333_0002, 0, 0);
        idle(2);
        irq_sel = 16'h00C0; idle(2);

        // R5/R6: overfill channel 2, full-source interrupt
        irq_sel = 16'h0030;
        for (int i = 0; i < 40; i++) step(1, 2, 32'h2200_0000 + i, 0, 0);
        idle(2);
        // R8: push and pop together on a full channel
        step(1, 2, 32'h22FF_0000, 1, 2);
        idle(1);
        ovr_phase = 1'b1;
        for (int i = 0; i < 33; i++) step(0, 0, 0, 1, 2);
        ovr_phase = 1'b0;
        // R8: push and pop together on an empty channel
        step(1, 2, 32'h2EEE_0001, 1, 2);
        idle(1);
        // R7: empty pop leaves others untouched
        step(0, 0, 0, 1, 7);
        idle(2);
        // R4: threshold out of range
        thresh = 6'd40; idle(2);
        thresh = 6'd0;  idle(2);

        // Mixed traffic on all channels
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 500 == 0) begin
                thresh = 6'(lfsr[4:0] + 5'd1);
                irq_sel = lfsr ^ 16'h9C3A;
            end
            step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), {lfsr, ~lfsr},
                 lfsr[5] & lfsr[6], int'(lfsr[9:7]));
        end
        idle(3);
        summary();
    end

endmodule